// File: doc/BRIEF.md
# Two-Wire Register Write Decoder for a Character Overlay

This block is the host-facing front end of a character overlay controller. It listens on a two-wire I2C bus as a slave and samples SCL and SDA on a fast system clock. It turns the byte stream from the host into single-cycle register writes, addressed by plane, row (0..15) and column (0..31). The display codes and the attribute/control registers are two planes of 16 x 32 bytes. Row 15 of the attribute plane holds the control registers.

Each byte after the slave address is classified by its top bits: a row selector, a column selector, or a data byte. Three framing styles are accepted in one transfer:
- explicit row, column and data for every write;
- a new column and data when the row is unchanged;
- a column byte with the streaming flag set, after which every byte is data and the location advances on its own.

The streaming state is left only through a stop or a start condition. A read transfer returns one byte from the `rd_data` input, which the surrounding logic wires to the register that holds the reset flag.

Bus state machine (`osd_i2c_link`):
- States: `L_IDLE`, `L_ADDR`, `L_AACK`, `L_WDATA`, `L_WACK`, `L_RDATA`, `L_SKIP`.
- A start moves from any state to `L_ADDR`. A stop moves from any state to `L_IDLE`.
- `L_ADDR` moves on the eighth SCL fall: to `L_AACK` on an address match, otherwise to `L_SKIP`.
- `L_AACK` moves on the ninth SCL fall: to `L_RDATA` for a read, or to `L_WDATA` for a write.
- `L_WDATA` moves to `L_WACK` on the eighth fall. `L_WACK` returns to `L_WDATA` on the ninth fall.
- `L_RDATA` moves to `L_SKIP` on the eighth fall.

Byte parser (`osd_i2c_parse`):
- States: `P_ROW`, `P_COL`, `P_DATA`, `P_STREAM`.
- A start or stop returns the parser to `P_ROW`.
- `P_ROW` moves to `P_COL` on a row byte.
- `P_COL` takes a row byte and stays in `P_COL`. On a column byte it moves to `P_STREAM` if the streaming flag is set, otherwise to `P_DATA`.
- `P_DATA` writes one byte and returns to `P_COL`.
- `P_STREAM` writes every byte and stays.

Top module: `osd_i2c_wdec`

## Requirements
- R1: Slave address byte 0x7A (write) and 0x7B (read) are acknowledged by pulling SDA low during the ninth SCL clock. Any other address gets no acknowledge, and the bytes after it produce no write.
- R2: A byte with bit 7 = 1 and bit 6 = 0 is a row selector. Bit 5 picks the plane (0 = display codes, 1 = attribute/control) and bits 3..0 give the row.
- R3: A byte with bit 7 = 0 is a column selector with the column in bits 4..0. Bit 6 = 1 enters streaming, and bit 6 = 0 expects exactly one data byte.
- R4: Outside streaming, the byte after a column selector is written once (`wr_en` high for one clock with plane, row, column and data). The parser then accepts a new row or a new column selector.
- R5: In streaming, every byte is written as data, including bytes shaped like selectors, and the column advances by one after each byte.
- R6: In streaming, column 31 wraps to 0 and the row increments, and row 15 wraps to row 0.
- R7: Streaming is left only by a stop or a start condition. After a stop, a new transfer parses selectors again.
- R8: A read returns `rd_data` MSB first as the first byte. Every later byte in the same transfer reads 0xFF because SDA is released.
- R9: Writes to attribute/control plane row 15, columns 24 and 31, are dropped (no `wr_en`). The streaming location still advances past them.
- R10: A pulse on SCL or SDA shorter than 3 system clocks after synchronisation has no effect on the decoded stream.
- R11: During and after reset, with the bus idle, `sda_oe` and `wr_en` are low.
- R12: A repeated start in the middle of a transfer makes the next byte a slave address, and parsing restarts at the row selector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock as seen on the pad |
| sda_in | input | 1 | Bus data as seen on the pad (wired-AND with the block's own drive) |
| rd_data | input | 8 | Value returned by a read transfer (reset-flag register) |
| sda_oe | output | 1 | High to pull SDA low |
| wr_en | output | 1 | One-clock register write strobe |
| wr_plane | output | 1 | 0 = display code plane, 1 = attribute/control plane |
| wr_row | output | 4 | Row of the write |
| wr_col | output | 5 | Column of the write |
| wr_data | output | 8 | Byte to write |

## Verification
The bench puts a byte shaped like a row selector inside a stream. A parser that leaves streaming would turn that byte into a row change instead of a write at row 0, column 1. It crosses column 31 and row 15 in one stream, and a wrong carry would land the write at the wrong place. It streams across the reserved column 24, and stops at column 31 of both planes to show that only the control plane is protected. A wrong decode would either write the reserved byte or stall the location. It injects two-clock spikes on SDA while SCL is high and on SCL while SCL is low. Without the filter these would look like a start condition or an extra bit, and the following write would be lost or misplaced. A second read byte must come back as 0xFF, which catches a design that keeps driving SDA.

// File: rtl/osd_i2c_pkg.sv
`timescale 1ns/1ps
package osd_i2c_pkg;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 5;
    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

    localparam logic [ROW_W-1:0] CTRL_ROW  = ROW_W'(15);
    localparam logic [COL_W-1:0] RSV_COL_A = COL_W'(24);
    localparam logic [COL_W-1:0] RSV_COL_B = COL_W'(31);

    typedef enum logic [2:0] {
        L_IDLE, L_ADDR, L_AACK, L_WDATA, L_WACK, L_RDATA, L_SKIP
    } link_t;

    typedef enum logic [1:0] {
        P_ROW, P_COL, P_DATA, P_STREAM
    } parse_t;

    function automatic logic is_reserved(input logic plane,
                                         input logic [ROW_W-1:0] row,
                                         input logic [COL_W-1:0] col);
        return plane && (row == CTRL_ROW) && ((col == RSV_COL_A) || (col == RSV_COL_B));
    endfunction
endpackage

// File: rtl/osd_i2c_filt.sv
`timescale 1ns/1ps
module osd_i2c_filt #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [SYNC_LEN-1:0] sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/osd_i2c_link.sv
`timescale 1ns/1ps
module osd_i2c_link
    import osd_i2c_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h3D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_val,
    output logic              frame_rst
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

    link_t st_q, st_d;
    logic scl_p, sda_p;
    logic start_c, stop_c, rise_c, fall_c;
    logic [BIT_CNT_W-1:0] cnt_q;
    logic [BYTE_W-1:0] sh_q, tx_q;
    logic rw_q;
    logic addr_hit;

    assign start_c  = scl && scl_p && sda_p && !sda;
    assign stop_c   = scl && scl_p && !sda_p && sda;
    assign rise_c   = scl && !scl_p;
    assign fall_c   = !scl && scl_p;
    assign addr_hit = (sh_q[BYTE_W-1:1] == SLAVE_ADDR);
    assign byte_val = sh_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= L_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            L_IDLE:  st_d = L_IDLE;
            L_ADDR:  if (fall_c && cnt_q == LAST_BIT) st_d = addr_hit ? L_AACK : L_SKIP;
            L_AACK:  if (fall_c) st_d = rw_q ? L_RDATA : L_WDATA;
            L_WDATA: if (fall_c && cnt_q == LAST_BIT) st_d = L_WACK;
            L_WACK:  if (fall_c) st_d = L_WDATA;
            L_RDATA: if (fall_c && cnt_q == LAST_BIT) st_d = L_SKIP;
            L_SKIP:  st_d = L_SKIP;
        endcase
        if (start_c)     st_d = L_ADDR;
        else if (stop_c) st_d = L_IDLE;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p     <= 1'b1;
            sda_p     <= 1'b1;
            cnt_q     <= '0;
            sh_q      <= '0;
            tx_q      <= '0;
            rw_q      <= 1'b0;
            sda_oe    <= 1'b0;
            byte_stb  <= 1'b0;
            frame_rst <= 1'b0;
        end else begin
            scl_p     <= scl;
            sda_p     <= sda;
            byte_stb  <= 1'b0;
            frame_rst <= start_c || stop_c;
            if (start_c || stop_c) begin
                cnt_q  <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (st_q)
                    L_ADDR, L_WDATA: begin
                        if (rise_c) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda};
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (fall_c && cnt_q == LAST_BIT) begin
                            cnt_q <= '0;
                            if (st_q == L_ADDR) begin
                                rw_q   <= sh_q[0];
                                sda_oe <= addr_hit;
                            end else begin
                                sda_oe   <= 1'b1;
                                byte_stb <= 1'b1;
                            end
                        end
                    end
                    L_AACK: begin
                        if (fall_c) begin
                            if (rw_q) begin
                                tx_q   <= rd_data;
                                sda_oe <= !rd_data[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    L_WACK: begin
                        if (fall_c) sda_oe <= 1'b0;
                    end
                    L_RDATA: begin
                        if (rise_c) cnt_q <= cnt_q + 1'b1;
                        if (fall_c) begin
                            if (cnt_q == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                cnt_q  <= '0;
                            end else begin
                                sda_oe <= !tx_q[BYTE_W-2];
                                tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    L_IDLE, L_SKIP: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/osd_i2c_parse.sv
`timescale 1ns/1ps
module osd_i2c_parse
    import osd_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_rst,
    input  logic              byte_stb,
    input  logic [BYTE_W-1:0] byte_val,
    output logic              wr_en,
    output logic              wr_plane,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic [BYTE_W-1:0] wr_data,
    output parse_t            mode
);
    localparam logic [COL_W-1:0] COL_LAST = '1;

    parse_t st_q, st_d;
    logic is_row, is_col;
    logic plane_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    assign is_row = byte_val[7] && !byte_val[6];
    assign is_col = !byte_val[7];
    assign mode   = st_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= P_ROW;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            P_ROW:    if (byte_stb && is_row) st_d = P_COL;
            P_COL:    if (byte_stb && is_col) st_d = byte_val[6] ? P_STREAM : P_DATA;
            P_DATA:   if (byte_stb) st_d = P_COL;
            P_STREAM: st_d = P_STREAM;
        endcase
        if (frame_rst) st_d = P_ROW;
    end

    // outputs and location
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plane_q  <= 1'b0;
            row_q    <= '0;
            col_q    <= '0;
            wr_en    <= 1'b0;
            wr_plane <= 1'b0;
            wr_row   <= '0;
            wr_col   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (byte_stb && !frame_rst) begin
                unique case (st_q)
                    P_ROW, P_COL: begin
                        if (is_row) begin
                            plane_q <= byte_val[5];
                            row_q   <= byte_val[ROW_W-1:0];
                        end else if (is_col && st_q == P_COL) begin
                            col_q <= byte_val[COL_W-1:0];
                        end
                    end
                    P_DATA, P_STREAM: begin
                        wr_en    <= !is_reserved(plane_q, row_q, col_q);
                        wr_plane <= plane_q;
                        wr_row   <= row_q;
                        wr_col   <= col_q;
                        wr_data  <= byte_val;
                        if (st_q == P_STREAM) begin
                            col_q <= col_q + 1'b1;
                            if (col_q == COL_LAST) row_q <= row_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/osd_i2c_wdec.sv
`timescale 1ns/1ps
module osd_i2c_wdec
    import osd_i2c_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h3D,
    parameter int         FILT_LEN   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic              wr_plane,
    output logic [ROW_W-1:0]  wr_row,
    output logic [COL_W-1:0]  wr_col,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, clean_lines;
    logic scl_f, sda_f;
    logic byte_stb, frame_rst;
    logic [BYTE_W-1:0] byte_val;
    parse_t pmode;

    assign raw_lines = {scl_in, sda_in};
    assign scl_f     = clean_lines[1];
    assign sda_f     = clean_lines[0];

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        osd_i2c_filt #(.SYNC_LEN(2), .FILT_LEN(FILT_LEN)) filt_i (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[g]),
            .dout (clean_lines[g])
        );
    end

    osd_i2c_link #(.SLAVE_ADDR(SLAVE_ADDR)) link_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_f),
        .sda      (sda_f),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .byte_stb (byte_stb),
        .byte_val (byte_val),
        .frame_rst(frame_rst)
    );

    osd_i2c_parse parse_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_rst(frame_rst),
        .byte_stb (byte_stb),
        .byte_val (byte_val),
        .wr_en    (wr_en),
        .wr_plane (wr_plane),
        .wr_row   (wr_row),
        .wr_col   (wr_col),
        .wr_data  (wr_data),
        .mode     (pmode)
    );
endmodule

// File: rtl/osd_i2c_wdec_chk.sv
`timescale 1ns/1ps
module osd_i2c_wdec_chk
    import osd_i2c_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             sda_oe,
    input logic             frame_rst,
    input parse_t           pmode,
    input logic             wr_en,
    input logic             wr_plane,
    input logic [ROW_W-1:0] wr_row,
    input logic [COL_W-1:0] wr_col
);
    // R4: each data byte gives a single-cycle strobe
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R9: reserved control registers never see a strobe
    a_r9_reserved_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_plane && wr_row == CTRL_ROW) |-> !(wr_col == RSV_COL_A || wr_col == RSV_COL_B));

    // R7: streaming persists until a start or stop
    a_r7_stream_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pmode == P_STREAM && !frame_rst) |=> (pmode == P_STREAM));

    // R1: SDA drive changes only while the clean clock is low
    a_r1_drive_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !frame_rst) |-> !scl_f);
endmodule

bind osd_i2c_wdec osd_i2c_wdec_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_oe   (sda_oe),
    .frame_rst(frame_rst),
    .pmode    (pmode),
    .wr_en    (wr_en),
    .wr_plane (wr_plane),
    .wr_row   (wr_row),
    .wr_col   (wr_col)
);

// File: tb/osd_i2c_wdec_tb_top.sv
`timescale 1ns/1ps
module osd_i2c_wdec_tb_top;
    localparam int Q = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [7:0] rd_data = 8'h00;
    logic sda_oe, wr_en, wr_plane;
    logic [3:0] wr_row;
    logic [4:0] wr_col;
    logic [7:0] wr_data;
    logic sda_bus;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit gl_scl = 0;
    bit gl_sda = 0;
    logic [17:0] lg [0:63];
    int nlog = 0;
    int base = 0;

    assign sda_bus = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    osd_i2c_wdec dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en),
        .wr_plane(wr_plane), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (wr_en && nlog < 64) begin
            lg[nlog] <= {wr_plane, wr_row, wr_col, wr_data};
            nlog <= nlog + 1;
        end
    end

    function automatic logic [17:0] pk(input logic p, input int r, input int c, input logic [7:0] d);
        return {p, 4'(r), 5'(c), d};
    endfunction

    task automatic chk_eq(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic mark();
        base = nlog;
    endtask

    task automatic wr_exp(input string tag, input int k, input logic [17:0] e);
        logic [17:0] got;
        got = (base + k < nlog) ? lg[base + k] : 18'h3FFFF;
        chk_eq(tag, $sformatf("write %0d", k), 32'(got), 32'(e));
    endtask

    task automatic wr_count(input string tag, input int n);
        chk_eq(tag, "write count", 32'(nlog - base), 32'(n));
    endtask

    task automatic i2c_start();
        sda_m = 1; #Q; scl_m = 1; #Q; sda_m = 0; #Q; scl_m = 0; #Q;
    endtask

    task automatic i2c_stop();
        sda_m = 0; #Q; scl_m = 1; #Q; sda_m = 1; #Q; #Q;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; #Q; scl_m = 1; #Q;
            if (gl_sda && i == 3 && b[i]) begin sda_m = 0; #20; sda_m = 1; end
            #Q; scl_m = 0; #Q;
            if (gl_scl && i == 3) begin scl_m = 1; #20; scl_m = 0; #Q; end
        end
        sda_m = 1; #Q; scl_m = 1; #Q; ack = !sda_bus; #Q; scl_m = 0; #Q;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1; #Q; scl_m = 1; #Q; b = {b[6:0], sda_bus}; #Q; scl_m = 0; #Q;
        end
        sda_m = !mack; #Q; scl_m = 1; #Q; #Q; scl_m = 0; #Q; sda_m = 1;
    endtask

    task automatic send_seq(input string tag, input logic [7:0] bs [$], input bit exp_ack);
        bit a;
        foreach (bs[i]) begin
            send_byte(bs[i], a);
            chk_eq(tag, $sformatf("ack byte %0d", i), 32'(a), 32'(exp_ack));
        end
    endtask

    task automatic t_reset();
        chk_eq("R11", "sda_oe after reset", 32'(sda_oe), 0);
        chk_eq("R11", "wr_en after reset", 32'(wr_en), 0);
    endtask

    task automatic t_fmt_a();
        mark(); i2c_start();
        send_seq("R1", '{8'h7A}, 1);
        send_seq("R2", '{8'h83, 8'h05, 8'h41, 8'hA2, 8'h07, 8'h17}, 1);
        i2c_stop();
        wr_count("R4", 2);
        wr_exp("R2", 0, pk(0, 3, 5, 8'h41));
        wr_exp("R2", 1, pk(1, 2, 7, 8'h17));
    endtask

    task automatic t_fmt_b();
        mark(); i2c_start();
        send_seq("R4", '{8'h7A, 8'h81, 8'h02, 8'h11, 8'h09, 8'h22}, 1);
        i2c_stop();
        wr_count("R4", 2);
        wr_exp("R3", 0, pk(0, 1, 2, 8'h11));
        wr_exp("R4", 1, pk(0, 1, 9, 8'h22));
    endtask

    task automatic t_stream_wrap();
        mark(); i2c_start();
        send_seq("R5", '{8'h7A, 8'h8F, 8'h5E, 8'h01, 8'h02, 8'h03, 8'h85}, 1);
        i2c_stop();
        wr_count("R5", 4);
        wr_exp("R5", 0, pk(0, 15, 30, 8'h01));
        wr_exp("R5", 1, pk(0, 15, 31, 8'h02));
        wr_exp("R6", 2, pk(0, 0, 0, 8'h03));
        wr_exp("R5", 3, pk(0, 0, 1, 8'h85));
    endtask

    task automatic t_a_to_c();
        mark(); i2c_start();
        send_seq("R3", '{8'h7A, 8'h82, 8'h01, 8'hAA, 8'h43, 8'hBB, 8'hCC}, 1);
        i2c_stop();
        wr_count("R3", 3);
        wr_exp("R3", 0, pk(0, 2, 1, 8'hAA));
        wr_exp("R3", 1, pk(0, 2, 3, 8'hBB));
        wr_exp("R5", 2, pk(0, 2, 4, 8'hCC));
    endtask

    task automatic t_reserved();
        mark(); i2c_start();
        send_seq("R9", '{8'h7A, 8'hAF, 8'h58, 8'h01, 8'h02}, 1);
        i2c_stop();
        i2c_start();
        send_seq("R7", '{8'h7A, 8'hAF, 8'h1F, 8'h33, 8'h17, 8'h44, 8'h8F, 8'h1F, 8'h55}, 1);
        i2c_stop();
        wr_count("R9", 3);
        wr_exp("R9", 0, pk(1, 15, 25, 8'h02));
        wr_exp("R7", 1, pk(1, 15, 23, 8'h44));
        wr_exp("R9", 2, pk(0, 15, 31, 8'h55));
    endtask

    task automatic t_bad_addr();
        mark(); i2c_start();
        send_seq("R1", '{8'h70, 8'h83, 8'h05, 8'h41}, 0);
        i2c_stop();
        wr_count("R1", 0);
    endtask

    task automatic t_read();
        logic [7:0] b;
        mark(); rd_data = 8'hA6;
        i2c_start();
        send_seq("R1", '{8'h7B}, 1);
        recv_byte(b, 1);
        chk_eq("R8", "read byte", 32'(b), 32'hA6);
        recv_byte(b, 0);
        chk_eq("R8", "extra read byte", 32'(b), 32'hFF);
        i2c_stop();
        wr_count("R8", 0);
    endtask

    task automatic t_restart();
        mark(); i2c_start();
        send_seq("R12", '{8'h7A, 8'h84, 8'h40, 8'h11}, 1);
        i2c_start();
        send_seq("R12", '{8'h7A, 8'h86, 8'h03, 8'h22}, 1);
        i2c_stop();
        wr_count("R12", 2);
        wr_exp("R12", 0, pk(0, 4, 0, 8'h11));
        wr_exp("R12", 1, pk(0, 6, 3, 8'h22));
    endtask

    task automatic t_glitch();
        mark(); i2c_start();
        send_seq("R10", '{8'h7A}, 1);
        gl_sda = 1;
        send_seq("R10", '{8'h88, 8'h0A}, 1);
        gl_sda = 0; gl_scl = 1;
        send_seq("R10", '{8'h5C}, 1);
        gl_scl = 0;
        i2c_stop();
        wr_count("R10", 1);
        wr_exp("R10", 0, pk(0, 8, 10, 8'h5C));
    endtask

    initial begin
        #100;
        t_reset();
        rst_n = 1;
        #200;
        t_reset();
        t_fmt_a();
        t_fmt_b();
        t_stream_wrap();
        t_a_to_c();
        t_reserved();
        t_bad_addr();
        t_read();
        t_restart();
        t_glitch();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1900000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule